// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between an on-chip request bus and an external asynchronous static RAM of 128K words by 8 bits. The RAM has a 17-bit address, a shared 8-bit data bus and four control strobes: an active-low primary select, an active-high secondary select, and active-low output and write enables. The bus side presents a request for a single cycle, and the controller turns it into a strobe sequence. Each phase of that sequence is a whole number of system clocks. The counts are derived at elaboration from the nanosecond minimums of the selected speed grade (35, 55 or 70 ns) and the clock period.

A read asserts both selects and the output enable for the access time. It captures the RAM data in the last cycle of that phase and returns it with a one-cycle valid pulse. A write holds the write enable low for a pulse sized to cover the pulse width, the address-to-end window and the data setup time. Address and data stay stable through one trailing cycle after the write enable rises. After any phase in which the RAM may have driven the bus, the controller waits out the output float time before it can drive data again.

By default the output enable stays high during writes. A parameter selects a mode that holds the output enable low through the write pulse. In that mode the pulse is stretched past the write-to-float time plus the data setup time, and write data is released only after the float time. A retention input deselects the RAM for low-supply operation. When that input is dropped, new accesses are held off for one read-cycle time.

Top module: `async_sram_ctrl`

## Requirements
- R1: During and after reset, with no request pending: ramCeN=1, ramCe2=0, ramOeN=1, ramWeN=1, ramDqOe=0, busy=0 and rspValid=0; whenever busy is 0 the RAM is deselected with both enables high and the data bus not driven.
- R2: A read selects the RAM with ramOeN=0 and ramWeN=1 for AA cycles, where AA is the larger of ceil(access/period) and ceil(output-enable access/period). The data present on ramDqIn in the last of those cycles is returned on rspData with rspValid high for exactly one cycle, the cycle after the phase ends (cycle AA+1 counted from the accepting edge).
- R3: A write holds ramWeN low for WP cycles, only while both selects are asserted, with the write data driven on ramDqOut. WP is the largest of ceil(pulse/period), ceil(address-valid-to-end/period) and ceil(data-setup/period). Address and data stay unchanged while ramWeN is low and for the one cycle after it rises, with selection still held.
- R4: A write keeps the controller busy for at least the write-cycle time in whole cycles: WP+1 cycles, extended with recovery cycles up to ceil(write-cycle/period) when that is larger.
- R5: After any cycle in which ramOeN was low, the controller does not raise ramDqOe while ramOeN is high until ceil(output-float/period) cycles have passed. A read keeps busy high for AA plus that many cycles.
- R6: With OE_LOW_WRITE=0, ramOeN stays high during writes. With OE_LOW_WRITE=1, ramOeN is low throughout the write pulse. In that mode the pulse is the larger of WP and ceil((write-float + data-setup)/period)+1, and ramDqOe rises only after the first ceil(write-float/period) cycles of the pulse. The float wait of R5 then also follows every write.
- R7: Requests are accepted only in a cycle where busy=0. A request presented while busy=1 is dropped and never reaches the RAM.
- R8: When sleepReq is high in an idle cycle, the next cycle has busy=1 with the RAM deselected (ramCeN=1, ramCe2=0). This takes priority over a simultaneous request, which is dropped. After sleepReq falls, busy stays high for ceil(read-cycle/period) cycles.
- R9: SPEED_NS selects the timing table: 35, 55 or 70. Each phase count is the ceiling of the nanosecond value over CLK_NS, and is at least 1 for a non-zero value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Single-cycle access request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 17 | Word address of the request |
| reqWdata | input | 8 | Write data |
| sleepReq | input | 1 | Level request for retention (deselected) mode |
| busy | output | 1 | High while no request can be accepted |
| rspValid | output | 1 | One-cycle pulse with read data |
| rspData | output | 8 | Read data |
| ramAddr | output | 17 | RAM address |
| ramCeN | output | 1 | RAM primary select, active low |
| ramCe2 | output | 1 | RAM secondary select, active high |
| ramOeN | output | 1 | RAM output enable, active low |
| ramWeN | output | 1 | RAM write enable, active low |
| ramDqOut | output | 8 | Data toward the RAM |
| ramDqOe | output | 1 | Drive enable for ramDqOut on the shared bus |
| ramDqIn | input | 8 | Data from the RAM |

## Verification
The assertions rely on two input conditions. A request is held for only one cycle, so nothing is issued twice. The RAM side returns data only through ramDqIn and never gates the controller's strobes. The stimulus drives requests at falling edges, waits for busy to drop before issuing, and pulses reqValid for one cycle. It injects a request during busy and one alongside sleepReq only to show that they are dropped. A bench RAM model releases read data only after the access and output-enable times. It measures each write pulse, the address window and the data setup against the grade's nanosecond values. It also counts any overlap between the controller driving the bus and the model still driving within its float time.

// File: rtl/async_sram_ctrl_pkg.sv
`timescale 1ns/1ps
package async_sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_WRITE, ST_WEND, ST_RECOV, ST_TURN, ST_SLEEP, ST_WAKE
  } ctrlState_e;

  // Strobes from control to datapath; pin strobes are for the coming cycle.
  typedef struct packed {
    logic sel;
    logic oeLo;
    logic weLo;
    logic drive;
    logic load;
    logic capture;
  } strobe_t;

  typedef struct packed {
    int unsigned accessNs;
    int unsigned oeAccessNs;
    int unsigned pulseNs;
    int unsigned setupNs;
    int unsigned windowNs;
    int unsigned cycleNs;
    int unsigned weFloatNs;
    int unsigned oeFloatNs;
  } gradeNs_t;

  function automatic gradeNs_t gradeTable(input int unsigned speedNs);
    gradeNs_t g;
    case (speedNs)
      35: g = '{accessNs:35, oeAccessNs:25, pulseNs:25, setupNs:20,
                windowNs:30, cycleNs:35, weFloatNs:15, oeFloatNs:25};
      55: g = '{accessNs:55, oeAccessNs:30, pulseNs:40, setupNs:25,
                windowNs:50, cycleNs:55, weFloatNs:20, oeFloatNs:30};
      default: g = '{accessNs:70, oeAccessNs:35, pulseNs:45, setupNs:30,
                windowNs:60, cycleNs:70, weFloatNs:25, oeFloatNs:35};
    endcase
    return g;
  endfunction

  function automatic int unsigned nsToCycles(input int unsigned ns, input int unsigned periodNs);
    if (ns == 0) return 0;
    return (ns + periodNs - 1) / periodNs;
  endfunction

  function automatic int unsigned maxU(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/async_sram_ctrl_fsm.sv
`timescale 1ns/1ps
module async_sram_ctrl_fsm
  import async_sram_ctrl_pkg::*;
#(
  parameter int unsigned AA_CYC       = 7,
  parameter int unsigned WP_CYC       = 6,
  parameter int unsigned WC_CYC       = 7,
  parameter int unsigned TURN_CYC     = 5,
  parameter int unsigned WHZ_CYC      = 3,
  parameter int unsigned WAKE_CYC     = 7,
  parameter bit          OE_LOW_WRITE = 1'b0,
  parameter int unsigned CNT_W        = 4
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    reqValid,
  input  logic    reqWrite,
  input  logic    sleepReq,
  output logic    busy,
  output strobe_t stb
);

  localparam int unsigned RECOV_CYC  = (WC_CYC > WP_CYC + 1) ? (WC_CYC - WP_CYC - 1) : 0;
  localparam int          DRIVE_FROM = int'(WP_CYC) - int'(WHZ_CYC);

  ctrlState_e state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt;
  logic lastCyc;

  assign lastCyc = (cnt == '0);

  always_comb begin
    nextState   = state;
    nextCnt     = lastCyc ? '0 : cnt - 1'b1;
    stb.load    = 1'b0;
    stb.capture = 1'b0;
    case (state)
      ST_IDLE: begin
        if (sleepReq) begin
          nextState = ST_SLEEP;
        end else if (reqValid) begin
          stb.load = 1'b1;
          if (reqWrite) begin
            nextState = ST_WRITE;
            nextCnt   = CNT_W'(WP_CYC - 1);
          end else begin
            nextState = ST_READ;
            nextCnt   = CNT_W'(AA_CYC - 1);
          end
        end
      end
      ST_READ: if (lastCyc) begin
        stb.capture = 1'b1;
        nextState   = ST_TURN;
        nextCnt     = CNT_W'(TURN_CYC - 1);
      end
      ST_WRITE: if (lastCyc) nextState = ST_WEND;
      ST_WEND: begin
        if (RECOV_CYC != 0) begin
          nextState = ST_RECOV;
          nextCnt   = CNT_W'(RECOV_CYC - 1);
        end else if (OE_LOW_WRITE) begin
          nextState = ST_TURN;
          nextCnt   = CNT_W'(TURN_CYC - 1);
        end else begin
          nextState = ST_IDLE;
        end
      end
      ST_RECOV: if (lastCyc) begin
        if (OE_LOW_WRITE) begin
          nextState = ST_TURN;
          nextCnt   = CNT_W'(TURN_CYC - 1);
        end else begin
          nextState = ST_IDLE;
        end
      end
      ST_TURN:  if (lastCyc) nextState = ST_IDLE;
      ST_SLEEP: if (!sleepReq) begin
        nextState = ST_WAKE;
        nextCnt   = CNT_W'(WAKE_CYC - 1);
      end
      ST_WAKE:  if (lastCyc) nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase

    stb.sel   = (nextState == ST_READ) || (nextState == ST_WRITE) || (nextState == ST_WEND);
    stb.oeLo  = (nextState == ST_READ) || (OE_LOW_WRITE && (nextState == ST_WRITE));
    stb.weLo  = (nextState == ST_WRITE);
    stb.drive = ((nextState == ST_WRITE) && (!OE_LOW_WRITE || (int'(nextCnt) < DRIVE_FROM)))
              || (nextState == ST_WEND);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nextState;
      cnt   <= nextCnt;
    end
  end

  assign busy = (state != ST_IDLE);

  // A read always ends in the float wait, so no accept can follow directly.
  AST_READ_TO_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_READ && lastCyc) |=> (state == ST_TURN)) // R5
    else $error("read did not enter float wait");

endmodule

// File: rtl/async_sram_ctrl_dp.sv
`timescale 1ns/1ps
module async_sram_ctrl_dp
  import async_sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W       = 17,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned TURN_CYC     = 5,
  parameter bit          OE_LOW_WRITE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] ramDqIn,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramCeN,
  output logic              ramCe2,
  output logic              ramOeN,
  output logic              ramWeN,
  output logic [DATA_W-1:0] ramDqOut,
  output logic              ramDqOe,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData
);

  localparam int unsigned TC_W = $clog2(TURN_CYC + 1) + 1;

  logic [TC_W-1:0] oeHighCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ramAddr  <= '0;
      ramCeN   <= 1'b1;
      ramCe2   <= 1'b0;
      ramOeN   <= 1'b1;
      ramWeN   <= 1'b1;
      ramDqOut <= '0;
      ramDqOe  <= 1'b0;
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      ramCeN   <= !stb.sel;
      ramCe2   <= stb.sel;
      ramOeN   <= !stb.oeLo;
      ramWeN   <= !stb.weLo;
      ramDqOe  <= stb.drive;
      rspValid <= stb.capture;
      if (stb.load) begin
        ramAddr  <= reqAddr;
        ramDqOut <= reqWdata;
      end
      if (stb.capture) rspData <= ramDqIn;
    end
  end

  // Cycles elapsed since the RAM outputs were last enabled (saturating).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          oeHighCnt <= TC_W'(TURN_CYC);
    else if (!ramOeN)    oeHighCnt <= '0;
    else if (oeHighCnt < TC_W'(TURN_CYC)) oeHighCnt <= oeHighCnt + 1'b1;
  end

  AST_WE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    !ramWeN |-> (!ramCeN && ramCe2)) // R3
    else $error("write strobe without selection");

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ramWeN) |-> ($stable(ramAddr) && !ramCeN)) // R3
    else $error("address moved around write strobe");

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ramWeN) && $past(ramDqOe)) |-> (ramDqOe && $stable(ramDqOut))) // R3
    else $error("write data moved before hold cycle");

  AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ramDqOe) && ramOeN) |-> (oeHighCnt >= TC_W'(TURN_CYC))) // R5
    else $error("bus driven inside float time");

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |=> !rspValid) // R2
    else $error("response valid longer than one cycle");

  AST_OE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!OE_LOW_WRITE && !ramWeN) |-> ramOeN) // R6
    else $error("output enable low during write in default mode");

endmodule

// File: rtl/async_sram_ctrl.sv
`timescale 1ns/1ps
module async_sram_ctrl
  import async_sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W       = 17,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned CLK_NS       = 5,
  parameter int unsigned SPEED_NS     = 35,
  parameter bit          OE_LOW_WRITE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              sleepReq,
  output logic              busy,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] ramAddr,
  output logic              ramCeN,
  output logic              ramCe2,
  output logic              ramOeN,
  output logic              ramWeN,
  output logic [DATA_W-1:0] ramDqOut,
  output logic              ramDqOe,
  input  logic [DATA_W-1:0] ramDqIn
);

  localparam gradeNs_t    G        = gradeTable(SPEED_NS);
  localparam int unsigned AA_CYC   = maxU(nsToCycles(G.accessNs, CLK_NS),
                                          nsToCycles(G.oeAccessNs, CLK_NS));
  localparam int unsigned WP_BASE  = maxU(nsToCycles(G.pulseNs, CLK_NS),
                                          maxU(nsToCycles(G.windowNs, CLK_NS),
                                               nsToCycles(G.setupNs, CLK_NS)));
  localparam int unsigned WP_OELO  = nsToCycles(G.weFloatNs + G.setupNs, CLK_NS) + 1;
  localparam int unsigned WP_CYC   = OE_LOW_WRITE ? maxU(WP_BASE, WP_OELO) : WP_BASE;
  localparam int unsigned WC_CYC   = nsToCycles(G.cycleNs, CLK_NS);
  localparam int unsigned TURN_CYC = maxU(nsToCycles(G.oeFloatNs, CLK_NS), 1);
  localparam int unsigned WHZ_CYC  = nsToCycles(G.weFloatNs, CLK_NS);
  localparam int unsigned WAKE_CYC = maxU(nsToCycles(G.cycleNs, CLK_NS), 1);
  localparam int unsigned MAX_CYC  = maxU(maxU(AA_CYC, WP_CYC), maxU(maxU(WC_CYC, TURN_CYC), WAKE_CYC));
  localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

  strobe_t stb;

  async_sram_ctrl_fsm #(
    .AA_CYC(AA_CYC), .WP_CYC(WP_CYC), .WC_CYC(WC_CYC), .TURN_CYC(TURN_CYC),
    .WHZ_CYC(WHZ_CYC), .WAKE_CYC(WAKE_CYC), .OE_LOW_WRITE(OE_LOW_WRITE), .CNT_W(CNT_W)
  ) uFsm (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite),
    .sleepReq(sleepReq), .busy(busy), .stb(stb)
  );

  async_sram_ctrl_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TURN_CYC(TURN_CYC), .OE_LOW_WRITE(OE_LOW_WRITE)
  ) uDp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .ramDqIn(ramDqIn), .ramAddr(ramAddr), .ramCeN(ramCeN), .ramCe2(ramCe2),
    .ramOeN(ramOeN), .ramWeN(ramWeN), .ramDqOut(ramDqOut), .ramDqOe(ramDqOe),
    .rspValid(rspValid), .rspData(rspData)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ramCeN && !ramCe2 && ramWeN && ramOeN && !ramDqOe)) // R1
    else $error("bus active while idle");

  AST_SLEEP_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (sleepReq && !busy) |=> (busy && ramCeN && !ramCe2)) // R8
    else $error("retention entry did not deselect");

endmodule

// File: tb/tb_async_sram_ctrl.sv
`timescale 1ns/1ps
module tb_sram_model #(
  parameter int T_AA  = 35,
  parameter int T_OE  = 25,
  parameter int T_WP  = 25,
  parameter int T_AW  = 30,
  parameter int T_DW  = 20,
  parameter int T_WHZ = 15,
  parameter int T_OHZ = 25
) (
  input  logic [16:0] addr,
  input  logic        ceN,
  input  logic        ce2,
  input  logic        oeN,
  input  logic        weN,
  input  logic [7:0]  dqOut,
  input  logic        dqOe,
  output logic [7:0]  dqIn,
  output int          violations,
  output int          contentions
);
  logic [7:0] mem [int];
  realtime tSel = 0, tOeFall = -1000, tWeFall = 0, tDataChg = 0, tDriveEnd = -1000;
  int      hzNs = 25;
  logic    oeLoAtWe = 1'b0;
  logic    rdDrive;
  logic    linger;

  assign rdDrive = !ceN && ce2 && !oeN && weN;

  initial begin violations = 0; contentions = 0; dqIn = 8'hEE; end

  always @(addr or ceN or ce2) tSel = $realtime;
  always @(negedge oeN) tOeFall = $realtime;
  always @(dqOut or dqOe) tDataChg = $realtime;
  always @(negedge weN) begin tWeFall = $realtime; oeLoAtWe = !oeN; end
  always @(negedge rdDrive) begin
    tDriveEnd = $realtime;
    hzNs = (!weN && !ceN && ce2 && !oeN) ? T_WHZ : T_OHZ;
  end

  always @(posedge weN) begin
    if (!ceN && ce2) begin
      if (($realtime - tWeFall) < T_WP) violations++;
      if (($realtime - tSel) < T_AW) violations++;
      if (!dqOe || (($realtime - tDataChg) < T_DW)) violations++;
      if (oeLoAtWe && (($realtime - tWeFall) <= (T_WHZ + T_DW))) violations++;
      mem[int'(addr)] = dqOut;
    end
  end

  initial begin
    #0.25;
    forever begin
      linger = (($realtime - tDriveEnd) < hzNs);
      if (rdDrive && (($realtime - tSel) >= T_AA - 1) && (($realtime - tOeFall) >= T_OE - 1))
        dqIn = mem.exists(int'(addr)) ? mem[int'(addr)] : 8'h00;
      else
        dqIn = 8'hEE;
      if (dqOe && (rdDrive || linger)) contentions++;
      #0.5;
    end
  end
endmodule

module tb_async_sram_ctrl;
  localparam int CLK_NS = 5;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (ns > 0 && c < 1) ? 1 : c;
  endfunction
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Expected counts for the 35 ns grade at a 5 ns clock (R9).
  localparam int E_AA    = 7;   // max(ceil 35/5, ceil 25/5)
  localparam int E_WP    = 6;   // max(ceil 25/5, ceil 30/5, ceil 20/5)
  localparam int E_WP_OL = 8;   // max(6, ceil 35/5 + 1)
  localparam int E_WC    = 7;
  localparam int E_TURN  = 5;
  localparam int E_WHZ   = 3;
  localparam int E_WAKE  = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, sleepReq = 1'b0;
  logic [16:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;

  logic busyA, rspValidA, ceNA, ce2A, oeNA, weNA, dqOeA;
  logic [7:0] rspDataA, dqOutA, dqInA;
  logic [16:0] addrA;
  logic busyB, rspValidB, ceNB, ce2B, oeNB, weNB, dqOeB;
  logic [7:0] rspDataB, dqOutB, dqInB;
  logic [16:0] addrB;
  int violA, contA, violB, contB;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  logic [7:0] qA [$];
  logic [7:0] qB [$];
  logic [7:0] shadow [int];

  always #2.5 clk = ~clk;

  async_sram_ctrl #(.CLK_NS(CLK_NS), .SPEED_NS(35), .OE_LOW_WRITE(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .sleepReq(sleepReq), .busy(busyA), .rspValid(rspValidA),
    .rspData(rspDataA), .ramAddr(addrA), .ramCeN(ceNA), .ramCe2(ce2A), .ramOeN(oeNA),
    .ramWeN(weNA), .ramDqOut(dqOutA), .ramDqOe(dqOeA), .ramDqIn(dqInA));

  async_sram_ctrl #(.CLK_NS(CLK_NS), .SPEED_NS(35), .OE_LOW_WRITE(1'b1)) dutOeLow (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .sleepReq(sleepReq), .busy(busyB), .rspValid(rspValidB),
    .rspData(rspDataB), .ramAddr(addrB), .ramCeN(ceNB), .ramCe2(ce2B), .ramOeN(oeNB),
    .ramWeN(weNB), .ramDqOut(dqOutB), .ramDqOe(dqOeB), .ramDqIn(dqInB));

  tb_sram_model ramA (.addr(addrA), .ceN(ceNA), .ce2(ce2A), .oeN(oeNA), .weN(weNA),
    .dqOut(dqOutA), .dqOe(dqOeA), .dqIn(dqInA), .violations(violA), .contentions(contA));
  tb_sram_model ramB (.addr(addrB), .ceN(ceNB), .ce2(ce2B), .oeN(oeNB), .weN(weNB),
    .dqOut(dqOutB), .dqOe(dqOeB), .dqIn(dqInB), .violations(violB), .contentions(contB));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Scoreboard monitor.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rspValidA) begin
        if (qA.size() == 0) check(1'b0, "R2", "unexpected response dut", int'(rspDataA), -1);
        else begin
          logic [7:0] e;
          e = qA.pop_front();
          check(rspDataA == e, "R2", "read data dut", int'(rspDataA), int'(e));
        end
      end
      if (rspValidB) begin
        if (qB.size() == 0) check(1'b0, "R2", "unexpected response dutOeLow", int'(rspDataB), -1);
        else begin
          logic [7:0] e;
          e = qB.pop_front();
          check(rspDataB == e, "R2", "read data dutOeLow", int'(rspDataB), int'(e));
        end
      end
    end
  end

  task automatic waitIdle();
    @(negedge clk);
    while (busyA || busyB) @(negedge clk);
  endtask

  task automatic access(input bit wr, input logic [16:0] a, input logic [7:0] d,
                        input bit intrude, input logic [16:0] ia);
    int busyCntA = 0, busyCntB = 0, weCntA = 0, weCntB = 0;
    int olA = 0, olB = 0, drvB = 0, rspAtA = 0, rspAtB = 0, idx = 0;
    waitIdle();
    if (!wr) begin
      logic [7:0] e;
      e = shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
      qA.push_back(e);
      qB.push_back(e);
    end else begin
      shadow[int'(a)] = d;
    end
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
    forever begin
      idx++;
      if (busyA) busyCntA++;
      if (busyB) busyCntB++;
      if (!weNA) weCntA++;
      if (!weNB) weCntB++;
      if (!weNA && !oeNA) olA++;
      if (!weNB && !oeNB) olB++;
      if (!weNB && dqOeB) drvB++;
      if (rspValidA) rspAtA = idx;
      if (rspValidB) rspAtB = idx;
      if (intrude && idx == 1) begin
        reqValid = 1'b1; reqWrite = 1'b1; reqAddr = ia; reqWdata = 8'h99;
      end else begin
        reqValid = 1'b0;
      end
      if ((!busyA && !busyB) || idx > 60) break;
      @(negedge clk);
    end
    if (wr) begin
      check(weCntA == E_WP, "R3 R9", "write pulse cycles dut", weCntA, E_WP);
      check(busyCntA == E_WP + 1 + imax(0, E_WC - E_WP - 1), "R4", "write busy dut",
            busyCntA, E_WP + 1 + imax(0, E_WC - E_WP - 1));
      check(olA == 0, "R6", "oe low during write dut", olA, 0);
      check(weCntB == E_WP_OL, "R6", "stretched pulse dutOeLow", weCntB, E_WP_OL);
      check(olB == E_WP_OL, "R6", "oe low through pulse dutOeLow", olB, E_WP_OL);
      check(drvB == E_WP_OL - E_WHZ, "R6", "data drive after float dutOeLow", drvB, E_WP_OL - E_WHZ);
      check(busyCntB == E_WP_OL + 1 + imax(0, E_WC - E_WP_OL - 1) + E_TURN, "R5 R6",
            "write busy dutOeLow", busyCntB, E_WP_OL + 1 + E_TURN);
    end else begin
      check(rspAtA == E_AA + 1, "R2", "read latency dut", rspAtA, E_AA + 1);
      check(rspAtB == E_AA + 1, "R2", "read latency dutOeLow", rspAtB, E_AA + 1);
      check(busyCntA == E_AA + E_TURN, "R5", "read busy dut", busyCntA, E_AA + E_TURN);
      check(busyCntB == E_AA + E_TURN, "R5", "read busy dutOeLow", busyCntB, E_AA + E_TURN);
    end
  endtask

  task automatic checkIdlePins(input string req);
    check(ceNA == 1 && ce2A == 0 && oeNA == 1 && weNA == 1 && dqOeA == 0, req,
          "idle pins dut", {ceNA, ce2A, oeNA, weNA, dqOeA}, 5'b10110);
    check(ceNB == 1 && ce2B == 0 && oeNB == 1 && weNB == 1 && dqOeB == 0, req,
          "idle pins dutOeLow", {ceNB, ce2B, oeNB, weNB, dqOeB}, 5'b10110);
    check(!busyA && !busyB && !rspValidA && !rspValidB, req, "idle status",
          {busyA, busyB, rspValidA, rspValidB}, 0);
  endtask

  initial begin
    #(200000 * CLK_NS);
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checkIdlePins("R1");                 // R1 during reset
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    checkIdlePins("R1");                 // R1 after release

    // Main traffic: writes then reads over several patterns (R2 R3 R4 R5 R6 R9).
    access(1'b1, 17'h00000, 8'hA5, 1'b0, '0);
    access(1'b1, 17'h1FFFF, 8'h5A, 1'b0, '0);
    access(1'b1, 17'h0ABCD, 8'hFF, 1'b0, '0);
    access(1'b0, 17'h00000, 8'h00, 1'b0, '0);
    access(1'b1, 17'h00001, 8'h00, 1'b0, '0);   // write right after a read: float wait
    access(1'b0, 17'h1FFFF, 8'h00, 1'b0, '0);
    access(1'b0, 17'h0ABCD, 8'h00, 1'b0, '0);
    access(1'b0, 17'h00001, 8'h00, 1'b0, '0);
    access(1'b0, 17'h12345, 8'h00, 1'b0, '0);   // never written: reads 0
    for (int i = 0; i < 6; i++)
      access(1'b1, 17'(17'h10000 + i * 17'h111), 8'(8'h30 + i * 7), 1'b0, '0);
    for (int i = 5; i >= 0; i--)
      access(1'b0, 17'(17'h10000 + i * 17'h111), 8'h00, 1'b0, '0);

    // R7: request during busy is dropped.
    access(1'b1, 17'h00200, 8'h11, 1'b1, 17'h00300);
    access(1'b1, 17'h00300, 8'h22, 1'b0, '0);
    access(1'b0, 17'h00200, 8'h00, 1'b1, 17'h00200);
    access(1'b0, 17'h00200, 8'h00, 1'b0, '0);   // R7 still 0x11, not 0x99
    access(1'b0, 17'h00300, 8'h00, 1'b0, '0);

    // R8: retention entry has priority over a simultaneous request.
    waitIdle();
    sleepReq = 1'b1; reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 17'h00200; reqWdata = 8'h77;
    @(negedge clk);
    reqValid = 1'b0;
    check(busyA && busyB, "R8", "busy in retention", {busyA, busyB}, 2'b11);
    check(ceNA && !ce2A && ceNB && !ce2B, "R8", "deselected in retention",
          {ceNA, ce2A, ceNB, ce2B}, 4'b1010);
    repeat (4) @(negedge clk);
    check(ceNA && !ce2A && weNA && busyA, "R8", "still deselected", {ceNA, ce2A, weNA, busyA}, 4'b1011);
    sleepReq = 1'b0;
    begin
      int wakeCnt = 0;
      for (int k = 0; k < 40; k++) begin
        @(negedge clk);
        if (busyA) wakeCnt++;
      end
      check(wakeCnt == E_WAKE, "R8", "wake delay cycles", wakeCnt, E_WAKE);
    end
    access(1'b0, 17'h00200, 8'h00, 1'b0, '0);   // R8 dropped write left 0x11
    checkIdlePins("R1");

    repeat (4) @(negedge clk);
    check(violA == 0, "R3", "strobe timing violations dut", violA, 0);
    check(violB == 0, "R6", "strobe timing violations dutOeLow", violB, 0);
    check(contA == 0, "R5", "bus contention dut", contA, 0);
    check(contB == 0, "R5", "bus contention dutOeLow", contB, 0);
    check(qA.size() == 0 && qB.size() == 0, "R2", "responses outstanding",
          qA.size() + qB.size(), 0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule